// File: doc/BRIEF.md
# Descriptor-Table DMA Engine with Doorbell

The engine moves blocks of dwords according to a table of descriptors that software builds in host memory. The table has up to 2^ID_W entries (128 by default). Each entry is eight dwords long and is followed, after the whole table, by one status dword per entry. Software writes the host table base and the local copy base through a small register port. It then rings a doorbell by writing the ID of the last descriptor it wants processed. The engine handles every descriptor from the one after the last completed ID up to and including that pointer, with IDs wrapping modulo the table size.

For each batch the engine first copies all pending descriptors into local memory at the local copy base. It also keeps their address and length fields in an internal RAM. It then performs each transfer one dword at a time through a request/acknowledge memory master. After each descriptor it writes a done word to that descriptor's status entry. When the batch ends it emits a single-cycle interrupt pulse. A doorbell that arrives while a batch is running moves the end of the range without restarting it.

Top module: `dtd_engine`

## Requirements
- R1: After reset the engine makes no memory or status request and holds irq low. The last completed ID is all ones, so the first batch begins at ID 0.
- R2: A register write to offset 0x10 is a doorbell. Its bits [ID_W-1:0] give the last pointer. The other register offsets are 0x00 and 0x04 for the host table base (low, high) and 0x08 and 0x0C for the local copy base (low, high). Writing a base register alone starts nothing. The bases are latched only by a doorbell accepted while idle. A batch covers IDs from last completed + 1 through the pointer, modulo 2^ID_W.
- R3: Before any data access of a batch, the eight dwords of every pending descriptor are read from host base + 32·id + 4·k and written to local base + 32·id + 4·k.
- R4: In a descriptor, dwords 0 and 1 hold the source address (low, high), dwords 2 and 3 hold the destination address (low, high), and bits [LEN_W-1:0] of dword 4 give the length in dwords. Dwords 5 to 7 are copied but otherwise unused.
- R5: For each descriptor, taken in ID order, dword k (k < length) is read from source + 4k and written to destination + 4k. Nothing beyond the length is written.
- R6: A descriptor of length zero makes no data access and still gets its status write.
- R7: After a descriptor finishes, one status write goes to host base + 32·2^ID_W + 4·id with value 0x00000001.
- R8: irq is a one-cycle pulse, given once per batch right after the last status write is acknowledged, and at no other time.
- R9: A doorbell whose pointer equals the current end of range is ignored; when idle, that end of range is the last completed ID. No access and no interrupt follow it.
- R10: A doorbell accepted while busy extends the batch. Every descriptor runs once and the extended batch gives one interrupt.
- R11: A request on the memory or status port stays asserted with stable address, data and direction until acknowledged, and the two ports are never requested at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory master request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Byte address of the dword |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge (one cycle) |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| st_req | output | 1 | Status write request |
| st_addr | output | 64 | Status entry byte address |
| st_data | output | 32 | Status word |
| st_ack | input | 1 | Status acknowledge (one cycle) |
| irq | output | 1 | Batch-complete interrupt pulse |

## Verification
The bench builds the engine with ID_W=3 and LEN_W=6, an eight-entry table, so every ID can be visited, including a batch that wraps from 7 to 0. Lengths sweep from 0 up to 8 dwords. That makes it possible to compute exact access counts per batch, the fill state of destination areas past their length, and the contents of every status entry. The smaller table also leaves room for batches with an ignored doorbell, an extension while busy, and freshly latched base addresses, all within a short run.

// File: rtl/dtd_pkg.sv
package dtd_pkg;
  localparam int AW = 64;
  localparam int DW = 32;
  localparam int DESC_DWORDS = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_PF_RD, S_PF_WR, S_EX_LD, S_EX_SET, S_EX_RD, S_EX_WR, S_ST
  } state_t;
endpackage

// File: rtl/dtd_regs.sv
module dtd_regs #(
  parameter int ID_W = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [4:0]           wr_addr,
  input  logic [31:0]          wr_data,
  input  logic                 busy,
  input  logic [ID_W-1:0]      last_done,
  output logic [63:0]          host_base,
  output logic [63:0]          loc_base,
  output logic [ID_W-1:0]      end_ptr,
  output logic                 pending
);
  logic [63:0] host_sh, loc_sh;
  logic        bell;
  logic        accept;

  assign bell   = wr_en && (wr_addr == 5'h10);
  assign accept = bell && (wr_data[ID_W-1:0] != end_ptr);

  always_ff @(posedge clk) begin
    if (rst) begin
      host_sh   <= '0;
      loc_sh    <= '0;
      host_base <= '0;
      loc_base  <= '0;
      end_ptr   <= '1;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          5'h00: host_sh[31:0]  <= wr_data;
          5'h04: host_sh[63:32] <= wr_data;
          5'h08: loc_sh[31:0]   <= wr_data;
          5'h0C: loc_sh[63:32]  <= wr_data;
          default: ;
        endcase
      end
      if (accept) begin
        end_ptr <= wr_data[ID_W-1:0];
        if (!busy) begin
          host_base <= host_sh;
          loc_base  <= loc_sh;
        end
      end
    end
  end

  assign pending = (end_ptr != last_done);

  p_ignore_same_ptr_r9: assert property (@(posedge clk) disable iff (rst)
    (bell && wr_data[ID_W-1:0] == end_ptr) |=> $stable(end_ptr));

  p_base_hold_busy_r2: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(host_base) && $stable(loc_base)));
endmodule

// File: rtl/dtd_desc_ram.sv
module dtd_desc_ram #(
  parameter int AW_I = 7,
  parameter int W    = 134
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW_I-1:0] waddr,
  input  logic [W-1:0]    wdata,
  input  logic [AW_I-1:0] raddr,
  output logic [W-1:0]    rdata
);
  localparam int DEPTH = 1 << AW_I;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dtd_seq.sv
module dtd_seq
  import dtd_pkg::*;
#(
  parameter int ID_W  = 7,
  parameter int LEN_W = 16,
  localparam int RW   = 128 + LEN_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [63:0]     host_base,
  input  logic [63:0]     loc_base,
  input  logic [ID_W-1:0] end_ptr,
  input  logic            pending,
  output logic [ID_W-1:0] last_done,
  output logic            busy,
  output logic            ram_we,
  output logic [ID_W-1:0] ram_waddr,
  output logic [RW-1:0]   ram_wdata,
  output logic [ID_W-1:0] ram_raddr,
  input  logic [RW-1:0]   ram_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [63:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic [31:0]     mem_rdata,
  output logic            st_req,
  output logic [63:0]     st_addr,
  output logic [31:0]     st_data,
  input  logic            st_ack,
  output logic            irq
);
  localparam int DEPTH = 1 << ID_W;
  localparam logic [63:0] STAT_OFF = 64'(DEPTH) << 5;

  state_t            state;
  logic [ID_W-1:0]   cur_id, seg_end;
  logic [2:0]        dw;
  logic [31:0]       buf_q;
  logic [63:0]       stg_src, stg_dst, src, dst;
  logic [LEN_W-1:0]  len, cnt;
  logic [63:0]       tbl_off, cnt_off;
  logic [LEN_W-1:0]  rd_len;

  assign tbl_off = {{(64-ID_W-5){1'b0}}, cur_id, dw, 2'b00};
  assign cnt_off = {{(64-LEN_W-2){1'b0}}, cnt, 2'b00};
  assign rd_len  = ram_rdata[LEN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cur_id    <= '0;
      seg_end   <= '0;
      last_done <= '1;
      dw        <= '0;
      buf_q     <= '0;
      stg_src   <= '0;
      stg_dst   <= '0;
      src       <= '0;
      dst       <= '0;
      len       <= '0;
      cnt       <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (state)
        S_IDLE: if (pending) begin
          cur_id  <= last_done + 1'b1;
          seg_end <= end_ptr;
          dw      <= '0;
          state   <= S_PF_RD;
        end
        S_PF_RD: if (mem_ack) begin
          buf_q <= mem_rdata;
          state <= S_PF_WR;
        end
        S_PF_WR: if (mem_ack) begin
          case (dw)
            3'd0: stg_src[31:0]  <= buf_q;
            3'd1: stg_src[63:32] <= buf_q;
            3'd2: stg_dst[31:0]  <= buf_q;
            3'd3: stg_dst[63:32] <= buf_q;
            default: ;
          endcase
          dw <= dw + 1'b1;
          if (dw == 3'd7) begin
            if (cur_id == seg_end) begin
              cur_id <= last_done + 1'b1;
              state  <= S_EX_LD;
            end else begin
              cur_id <= cur_id + 1'b1;
              state  <= S_PF_RD;
            end
          end else begin
            state <= S_PF_RD;
          end
        end
        S_EX_LD: state <= S_EX_SET;
        S_EX_SET: begin
          src   <= ram_rdata[RW-1 -: 64];
          dst   <= ram_rdata[RW-65 -: 64];
          len   <= rd_len;
          cnt   <= '0;
          state <= (rd_len == '0) ? S_ST : S_EX_RD;
        end
        S_EX_RD: if (mem_ack) begin
          buf_q <= mem_rdata;
          state <= S_EX_WR;
        end
        S_EX_WR: if (mem_ack) begin
          if (cnt == len - 1'b1) begin
            state <= S_ST;
          end else begin
            cnt   <= cnt + 1'b1;
            state <= S_EX_RD;
          end
        end
        S_ST: if (st_ack) begin
          last_done <= cur_id;
          cur_id    <= cur_id + 1'b1;
          if (cur_id == seg_end) begin
            if (end_ptr != seg_end) begin
              seg_end <= end_ptr;
              dw      <= '0;
              state   <= S_PF_RD;
            end else begin
              irq   <= 1'b1;
              state <= S_IDLE;
            end
          end else begin
            state <= S_EX_LD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign ram_we    = (state == S_PF_WR) && mem_ack && (dw == 3'd4);
  assign ram_waddr = cur_id;
  assign ram_wdata = {stg_src, stg_dst, buf_q[LEN_W-1:0]};
  assign ram_raddr = cur_id;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = buf_q;
    case (state)
      S_PF_RD: begin mem_req = 1'b1; mem_addr = host_base + tbl_off; end
      S_PF_WR: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = loc_base + tbl_off; end
      S_EX_RD: begin mem_req = 1'b1; mem_addr = src + cnt_off; end
      S_EX_WR: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = dst + cnt_off; end
      default: ;
    endcase
  end

  assign st_req  = (state == S_ST);
  assign st_addr = host_base + STAT_OFF + {{(62-ID_W){1'b0}}, cur_id, 2'b00};
  assign st_data = 32'h0000_0001;

  p_mem_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  p_st_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (st_req && !st_ack) |=> (st_req && $stable(st_addr)));
  p_one_port_r11: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && st_req));
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  p_irq_after_status_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(st_req && st_ack));
  p_status_done_r7: assert property (@(posedge clk) disable iff (rst)
    st_ack |=> (last_done == $past(cur_id)));
endmodule

// File: rtl/dtd_engine.sv
module dtd_engine #(
  parameter int ID_W  = 7,
  parameter int LEN_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        st_req,
  output logic [63:0] st_addr,
  output logic [31:0] st_data,
  input  logic        st_ack,
  output logic        irq
);
  localparam int RW = 128 + LEN_W;

  logic [63:0]     host_base, loc_base;
  logic [ID_W-1:0] end_ptr, last_done;
  logic            pending, busy;
  logic            ram_we;
  logic [ID_W-1:0] ram_waddr, ram_raddr;
  logic [RW-1:0]   ram_wdata, ram_rdata;

  dtd_regs #(.ID_W(ID_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(reg_we), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .busy(busy), .last_done(last_done), .host_base(host_base), .loc_base(loc_base),
    .end_ptr(end_ptr), .pending(pending)
  );

  dtd_desc_ram #(.AW_I(ID_W), .W(RW)) ram_i (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  dtd_seq #(.ID_W(ID_W), .LEN_W(LEN_W)) seq_i (
    .clk(clk), .rst(rst), .host_base(host_base), .loc_base(loc_base),
    .end_ptr(end_ptr), .pending(pending), .last_done(last_done), .busy(busy),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .st_req(st_req), .st_addr(st_addr), .st_data(st_data), .st_ack(st_ack), .irq(irq)
  );
endmodule

// File: tb/dtd_engine_tb.sv
module dtd_engine_tb_top;
  localparam int ID_W  = 3;
  localparam int LEN_W = 6;
  localparam int N     = 1 << ID_W;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        mem_req, mem_we, st_req, irq;
  logic [63:0] mem_addr, st_addr;
  logic [31:0] mem_wdata, st_data;
  logic        mem_ack = 1'b0, st_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #5 clk = ~clk;

  dtd_engine #(.ID_W(ID_W), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .st_req(st_req), .st_addr(st_addr), .st_data(st_data), .st_ack(st_ack), .irq(irq)
  );

  localparam logic [63:0] HOST1 = 64'h1_0000_0000;
  localparam logic [63:0] LOC1  = 64'h0000_2000;
  localparam logic [63:0] HOST2 = 64'h1_0000_4000;
  localparam logic [63:0] LOC2  = 64'h0000_6000;
  localparam logic [63:0] SRCB  = 64'h1_0004_0000;
  localparam logic [63:0] DSTB  = 64'h0008_0000;

  logic [31:0] mem [longint unsigned];
  int checks = 0, errors = 0;
  int irq_cnt = 0, acc_cnt = 0, st_cnt = 0, pf_wr = 0, pf_snap = -1;
  bit data_seen = 0;
  int st_ids [$];
  logic [63:0] cur_h = HOST1, cur_l = LOC1;
  int e_len [N];

  function automatic longint unsigned k(input logic [63:0] a);
    return longint'(a >> 2);
  endfunction

  function automatic logic [31:0] rd(input logic [63:0] a);
    if (mem.exists(k(a))) return mem[k(a)];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    st_ack  <= 1'b0;
    if (irq) irq_cnt++;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      acc_cnt++;
      if (mem_we) begin
        mem[k(mem_addr)] = mem_wdata;
        if (mem_addr >= cur_l && mem_addr < cur_l + 64'(N*32)) pf_wr++;
      end else begin
        mem_rdata <= rd(mem_addr);
        if (!(mem_addr >= cur_h && mem_addr < cur_h + 64'(N*32)) && !data_seen) begin
          data_seen = 1;
          pf_snap = pf_wr;
        end
      end
    end
    if (st_req && !st_ack) begin
      st_ack <= 1'b1;
      st_cnt++;
      mem[k(st_addr)] = st_data;
      st_ids.push_back(int'((st_addr - cur_h - 64'(N*32)) >> 2));
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_bases(input logic [63:0] h, input logic [63:0] l);
    wr_reg(5'h00, h[31:0]); wr_reg(5'h04, h[63:32]);
    wr_reg(5'h08, l[31:0]); wr_reg(5'h0C, l[63:32]);
  endtask

  function automatic logic [31:0] dval(input int g, input int id, input int j);
    return 32'hC0DE_0000 + 32'(g * 32'h1000) + 32'(id * 32'h40) + 32'(j);
  endfunction

  // build descriptor id of generation g in table h; dst area pre-filled with a marker
  task automatic mk_desc(input logic [63:0] h, input int g, input int id, input int len);
    logic [63:0] s, d, t;
    s = SRCB + 64'(g * 32'h1000) + 64'(id * 32'h100);
    d = DSTB + 64'(g * 32'h1000) + 64'(id * 32'h100);
    t = h + 64'(id * 32);
    mem[k(t)]      = s[31:0];
    mem[k(t + 4)]  = s[63:32];
    mem[k(t + 8)]  = d[31:0];
    mem[k(t + 12)] = d[63:32];
    mem[k(t + 16)] = 32'hFFFF_FF00 | 32'(len);
    for (int j = 5; j < 8; j++) mem[k(t + 64'(4*j))] = 32'hA5A5_0000 | 32'(id << 4) | 32'(j);
    for (int j = 0; j < len; j++) mem[k(s + 64'(4*j))] = dval(g, id, j);
    for (int j = 0; j <= len; j++) mem[k(d + 64'(4*j))] = 32'hDEAD_BEEF;
    mem[k(h + 64'(N*32) + 64'(4*id))] = 32'h0;
    e_len[id] = len;
  endtask

  task automatic verify(input logic [63:0] h, input logic [63:0] l, input int g, input int id);
    logic [63:0] d, t;
    int len;
    len = e_len[id];
    d = DSTB + 64'(g * 32'h1000) + 64'(id * 32'h100);
    t = 64'(id * 32);
    for (int j = 0; j < len; j++)
      check(rd(d + 64'(4*j)) == dval(g, id, j), "R5 data copy", rd(d + 64'(4*j)), dval(g, id, j));
    check(rd(d + 64'(4*len)) == 32'hDEAD_BEEF, len == 0 ? "R6 zero length untouched" : "R5 no overrun",
          rd(d + 64'(4*len)), 32'hDEAD_BEEF);
    for (int j = 0; j < 8; j++)
      check(rd(l + t + 64'(4*j)) == rd(h + t + 64'(4*j)), "R3 R4 local table copy",
            rd(l + t + 64'(4*j)), rd(h + t + 64'(4*j)));
    check(rd(h + 64'(N*32) + 64'(4*id)) == 32'h1, "R7 status word", rd(h + 64'(N*32) + 64'(4*id)), 1);
  endtask

  task automatic clr_track();
    acc_cnt = 0; st_cnt = 0; pf_wr = 0; pf_snap = -1; data_seen = 0;
    st_ids.delete();
  endtask

  task automatic wait_irq(input int start_cnt);
    for (int c = 0; c < 20000 && irq_cnt == start_cnt; c++) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_sim();
  end

  initial begin
    int i0, exp_acc, sum;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!mem_req && !st_req && !irq, "R1 idle after reset", {mem_req, st_req, irq}, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check(!mem_req && !st_req && !irq, "R1 idle after release", {mem_req, st_req, irq}, 0);

    // R2: base writes alone start nothing
    set_bases(HOST1, LOC1);
    clr_track();
    repeat (30) @(negedge clk);
    check(acc_cnt == 0 && irq_cnt == 0, "R2 base writes start nothing", acc_cnt, 0);

    // Batch A: ids 0..2 with lengths 1,0,3
    mk_desc(HOST1, 1, 0, 1);
    mk_desc(HOST1, 1, 1, 0);
    mk_desc(HOST1, 1, 2, 3);
    clr_track();
    i0 = irq_cnt;
    wr_reg(5'h10, 32'd2);
    wait_irq(i0);
    check(irq_cnt == i0 + 1, "R8 one irq per batch", irq_cnt - i0, 1);
    for (int id = 0; id < 3; id++) verify(HOST1, LOC1, 1, id);
    check(acc_cnt == 3*16 + 2*4, "R6 access count", acc_cnt, 3*16 + 2*4);
    check(pf_snap == 24, "R3 prefetch before data", pf_snap, 24);
    check(st_cnt == 3, "R7 status count", st_cnt, 3);
    for (int q = 0; q < st_ids.size(); q++)
      check(st_ids[q] == q, "R5 R7 status order", st_ids[q], q);

    // R9: doorbell equal to last completed ID is ignored
    clr_track();
    i0 = irq_cnt;
    wr_reg(5'h10, 32'd2);
    repeat (60) @(negedge clk);
    check(acc_cnt == 0 && st_cnt == 0, "R9 ignored doorbell no access", acc_cnt + st_cnt, 0);
    check(irq_cnt == i0, "R9 ignored doorbell no irq", irq_cnt - i0, 0);

    // Batch B: wrap from 3 through 7, 0, 1 with a length sweep
    sum = 0;
    for (int q = 0; q < 7; q++) begin
      int id;
      id = (3 + q) % N;
      mk_desc(HOST1, 2, id, (id * 5) % 9);
      sum += (id * 5) % 9;
    end
    mem[k(HOST1 + 64'(N*32) + 64'(4*2))] = 32'h0;
    clr_track();
    i0 = irq_cnt;
    wr_reg(5'h10, 32'd1);
    wait_irq(i0);
    check(irq_cnt == i0 + 1, "R8 R2 wrap batch irq", irq_cnt - i0, 1);
    for (int q = 0; q < 7; q++) verify(HOST1, LOC1, 2, (3 + q) % N);
    check(rd(HOST1 + 64'(N*32) + 8) == 0, "R2 id outside range untouched", rd(HOST1 + 64'(N*32) + 8), 0);
    exp_acc = 7*16 + 2*sum;
    check(acc_cnt == exp_acc, "R5 R6 wrap access count", acc_cnt, exp_acc);
    check(pf_snap == 56, "R3 wrap prefetch first", pf_snap, 56);
    for (int q = 0; q < st_ids.size(); q++)
      check(st_ids[q] == (3 + q) % N, "R2 wrap order", st_ids[q], (3 + q) % N);

    // Batch C: 2..4, extended to 6 while busy
    for (int id = 2; id <= 7; id++) mk_desc(HOST1, 3, id, id - 1);
    clr_track();
    i0 = irq_cnt;
    wr_reg(5'h10, 32'd4);
    repeat (10) @(negedge clk);
    wr_reg(5'h10, 32'd6);
    wait_irq(i0);
    repeat (100) @(negedge clk);
    check(irq_cnt == i0 + 1, "R10 single irq after extension", irq_cnt - i0, 1);
    for (int id = 2; id <= 6; id++) verify(HOST1, LOC1, 3, id);
    check(rd(HOST1 + 64'(N*32) + 28) == 0, "R10 beyond extension untouched", rd(HOST1 + 64'(N*32) + 28), 0);
    exp_acc = 5*16 + 2*(1+2+3+4+5);
    check(acc_cnt == exp_acc, "R10 no descriptor repeated", acc_cnt, exp_acc);
    check(st_cnt == 5, "R10 status count", st_cnt, 5);

    // Batch D: new bases latched by idle doorbell, range 7..0
    set_bases(HOST2, LOC2);
    mk_desc(HOST2, 4, 7, 2);
    mk_desc(HOST2, 4, 0, 4);
    cur_h = HOST2; cur_l = LOC2;
    clr_track();
    i0 = irq_cnt;
    wr_reg(5'h10, 32'd0);
    wait_irq(i0);
    check(irq_cnt == i0 + 1, "R8 batch D irq", irq_cnt - i0, 1);
    verify(HOST2, LOC2, 4, 7);
    verify(HOST2, LOC2, 4, 0);
    check(pf_wr == 16, "R2 new local base used", pf_wr, 16);
    check(acc_cnt == 2*16 + 2*6, "R2 batch D access count", acc_cnt, 44);

    finish_sim();
  end
endmodule